// File: doc/BRIEF.md
# Accumulator ALU with Five Status Flags

This block is the arithmetic/logic core of a small 8-bit datapath. It keeps an accumulator and a second operand register that nothing outside the block can read. The surrounding control logic uses two strobes. A load strobe places a byte in the operand register. An execute strobe applies the selected operation to the accumulator and the operand register. The result goes back into the accumulator, except for compare and for the operand-register increment and decrement.

Every flag-writing operation updates all five status bits: sign, zero, nibble carry, even parity and carry. They are presented as one packed status byte. Increment and decrement can act on the operand register instead of the accumulator. In that case they change only the operand register and the flags, so a zero test on that count is possible without disturbing the accumulator.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low and after its release, `acc_out` is 0, `flags_out` is 8'h02 and the hidden operand register holds 0.
- R2: With `load_en` high, `operand` is written into the operand register at the clock edge. When `load_en` and `exec_en` are high in the same cycle, the operation uses the previously held operand, and the load wins over any operand-register write.
- R3: Code 0 (add) sets the accumulator to acc+opnd, and code 1 (add with carry) to acc+opnd+CY, both truncated to 8 bits. CY is set to the carry out of bit 7.
- R4: Code 2 (subtract) computes acc-opnd, and code 3 (subtract with borrow) computes acc-opnd-CY. Code 7 (compare) computes acc-opnd but leaves the accumulator unchanged. For all three, CY is 1 exactly when a borrow occurs.
- R5: Code 4 (AND), code 5 (OR) and code 6 (XOR) write the bitwise result to the accumulator and clear CY. AND sets AC, while OR and XOR clear it.
- R6: Code 8 increments the accumulator and code 9 decrements it. Code 10 increments the operand register and code 11 decrements it, leaving the accumulator unchanged. None of these four codes changes CY.
- R7: After any flag-writing operation, S (status bit 7) equals bit 7 of the result.
- R8: After any flag-writing operation, Z (status bit 6) is 1 exactly when the result is 0. This includes results written to the operand register.
- R9: AC (status bit 4) is the carry from bit 3 into bit 4 of the internal addition. Subtraction is performed as acc + ~opnd + (1 for subtract or compare, ~CY for subtract with borrow). Increment adds 1 and decrement adds 8'hFF.
- R10: After any flag-writing operation, P (status bit 2) is 1 when the result has an even number of 1 bits and 0 when the count is odd.
- R11: `flags_out` is packed as {S, Z, 0, AC, 0, P, 1, CY}, from bit 7 down to bit 0.
- R12: Code 12 copies the operand register into the accumulator and leaves the flags unchanged. Codes 13 to 15 change nothing.
- R13: With `exec_en` low, the accumulator and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write `operand` into the operand register |
| exec_en | input | 1 | Perform the operation selected by `op_code` |
| op_code | input | 4 | Operation select |
| operand | input | DATA_W | Byte for the operand register |
| acc_out | output | DATA_W | Accumulator contents |
| flags_out | output | 8 | Packed status byte |

## Verification
The assertions check the following on every cycle:
- the fixed bits of the status byte;
- that sign, zero and parity agree with the accumulator after each accumulator-writing operation;
- that compare and idle cycles leave the accumulator alone;
- that increment and decrement leave carry alone;
- that logical operations clear carry.

Only the bench's scenarios can show the following:
- the actual sums, borrows and nibble carries;
- which operand a simultaneous load and execute uses;
- the zero flag from operand-register counts, which is visible only through later operations.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_ADC  = 4'h1,
      OP_SUB  = 4'h2,
      OP_SBB  = 4'h3,
      OP_AND  = 4'h4,
      OP_OR   = 4'h5,
      OP_XOR  = 4'h6,
      OP_CMP  = 4'h7,
      OP_INCA = 4'h8,
      OP_DECA = 4'h9,
      OP_INCT = 4'hA,
      OP_DECT = 4'hB,
      OP_MOVA = 4'hC
   } alu_op_e;

   typedef struct packed {
      logic s;
      logic z;
      logic ac;
      logic p;
      logic cy;
   } alu_flags_t;

   localparam int FLAG_BYTE_W = 8;

   function automatic logic [FLAG_BYTE_W-1:0] pack_flags(alu_flags_t f);
      return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
   endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int DATA_W       = 8,
   parameter bit SPLIT_NIBBLE = 1'b1
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              c_nib,
   output logic              c_out
);
   localparam int HI_W = DATA_W - 4;

   generate
      if (SPLIT_NIBBLE) begin : g_split
         logic [4:0]    lo;
         logic [HI_W:0] hi;
         assign lo    = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'b0000, cin};
         assign hi    = {1'b0, x[DATA_W-1:4]} + {1'b0, y[DATA_W-1:4]}
                        + {{HI_W{1'b0}}, lo[4]};
         assign sum   = {hi[HI_W-1:0], lo[3:0]};
         assign c_nib = lo[4];
         assign c_out = hi[HI_W];
      end else begin : g_flat
         logic [DATA_W:0] full;
         assign full  = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
         assign sum   = full[DATA_W-1:0];
         assign c_nib = x[4] ^ y[4] ^ full[4];
         assign c_out = full[DATA_W];
      end
   endgenerate
endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic              ac
);
   always_comb begin
      res = a & b;
      ac  = 1'b0;
      unique case (op)
         OP_AND:  begin res = a & b; ac = 1'b1; end
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         default: res = a & b;
      endcase
   end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] res,
   output logic              s,
   output logic              z,
   output logic              p
);
   assign s = res[DATA_W-1];
   assign z = ~|res;
   assign p = ~^res;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SPLIT_NIBBLE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_en,
   input  logic                   exec_en,
   input  logic [3:0]             op_code,
   input  logic [DATA_W-1:0]      operand,
   output logic [DATA_W-1:0]      acc_out,
   output logic [FLAG_BYTE_W-1:0] flags_out
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("acc_alu: DATA_W must be at least 8");
      end
   endgenerate

   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] ZERO_W   = {DATA_W{1'b0}};

   logic [DATA_W-1:0] acc_q, tmp_q;
   alu_flags_t        flg_q, flg_d;
   alu_op_e           op;

   logic [DATA_W-1:0] add_x, add_y, add_sum, log_res, result;
   logic              add_cin, add_cnib, add_cout, log_ac;
   logic              is_sub, use_logic, keep_cy, do_mov;
   logic              wr_acc, wr_tmp, wr_flags;
   logic              f_s, f_z, f_p;

   assign op = alu_op_e'(op_code);

   always_comb begin
      add_x     = acc_q;
      add_y     = tmp_q;
      add_cin   = 1'b0;
      is_sub    = 1'b0;
      use_logic = 1'b0;
      keep_cy   = 1'b0;
      do_mov    = 1'b0;
      wr_acc    = 1'b0;
      wr_tmp    = 1'b0;
      wr_flags  = 1'b0;
      case (op)
         OP_ADD: begin wr_acc = 1'b1; wr_flags = 1'b1; end
         OP_ADC: begin add_cin = flg_q.cy; wr_acc = 1'b1; wr_flags = 1'b1; end
         OP_SUB: begin
            add_y = ~tmp_q; add_cin = 1'b1; is_sub = 1'b1;
            wr_acc = 1'b1; wr_flags = 1'b1;
         end
         OP_SBB: begin
            add_y = ~tmp_q; add_cin = ~flg_q.cy; is_sub = 1'b1;
            wr_acc = 1'b1; wr_flags = 1'b1;
         end
         OP_CMP: begin
            add_y = ~tmp_q; add_cin = 1'b1; is_sub = 1'b1; wr_flags = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR: begin
            use_logic = 1'b1; wr_acc = 1'b1; wr_flags = 1'b1;
         end
         OP_INCA: begin
            add_y = ZERO_W; add_cin = 1'b1; keep_cy = 1'b1;
            wr_acc = 1'b1; wr_flags = 1'b1;
         end
         OP_DECA: begin
            add_y = ALL_ONES; keep_cy = 1'b1; wr_acc = 1'b1; wr_flags = 1'b1;
         end
         OP_INCT: begin
            add_x = tmp_q; add_y = ZERO_W; add_cin = 1'b1; keep_cy = 1'b1;
            wr_tmp = 1'b1; wr_flags = 1'b1;
         end
         OP_DECT: begin
            add_x = tmp_q; add_y = ALL_ONES; keep_cy = 1'b1;
            wr_tmp = 1'b1; wr_flags = 1'b1;
         end
         OP_MOVA: begin do_mov = 1'b1; wr_acc = 1'b1; end
         default: ;
      endcase
   end

   alu_adder #(.DATA_W(DATA_W), .SPLIT_NIBBLE(SPLIT_NIBBLE)) u_adder (
      .x(add_x), .y(add_y), .cin(add_cin),
      .sum(add_sum), .c_nib(add_cnib), .c_out(add_cout)
   );

   alu_logic #(.DATA_W(DATA_W)) u_logic (
      .op(op), .a(acc_q), .b(tmp_q), .res(log_res), .ac(log_ac)
   );

   assign result = use_logic ? log_res : (do_mov ? tmp_q : add_sum);

   alu_flag_gen #(.DATA_W(DATA_W)) u_flags (
      .res(result), .s(f_s), .z(f_z), .p(f_p)
   );

   always_comb begin
      flg_d.s  = f_s;
      flg_d.z  = f_z;
      flg_d.p  = f_p;
      flg_d.ac = use_logic ? log_ac : add_cnib;
      if (keep_cy)        flg_d.cy = flg_q.cy;
      else if (use_logic) flg_d.cy = 1'b0;
      else if (is_sub)    flg_d.cy = ~add_cout;
      else                flg_d.cy = add_cout;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= ZERO_W;
         tmp_q <= ZERO_W;
         flg_q <= '0;
      end else begin
         if (exec_en) begin
            if (wr_acc)   acc_q <= result;
            if (wr_flags) flg_q <= flg_d;
            if (wr_tmp)   tmp_q <= add_sum;
         end
         if (load_en) tmp_q <= operand;
      end
   end

   assign acc_out   = acc_q;
   assign flags_out = pack_flags(flg_q);
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exec_en,
   input logic [3:0]        op_code,
   input logic [DATA_W-1:0] acc_out,
   input logic [7:0]        flags_out
);
   logic acc_flag_op, logic_op, incdec_op, cmp_op, quiet_op;
   assign acc_flag_op = exec_en && (op_code <= 4'h6 || op_code == 4'h8 || op_code == 4'h9);
   assign logic_op    = exec_en && op_code >= 4'h4 && op_code <= 4'h6;
   assign incdec_op   = exec_en && op_code >= 4'h8 && op_code <= 4'hB;
   assign cmp_op      = exec_en && op_code == 4'h7;
   assign quiet_op    = exec_en && op_code >= 4'hC;

   assert_fixed_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flags_out[5] == 1'b0 && flags_out[3] == 1'b0 && flags_out[1] == 1'b1);

   assert_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_flag_op |=> flags_out[7] == acc_out[DATA_W-1]);

   assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_flag_op |=> flags_out[6] == (acc_out == '0));

   assert_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_flag_op |=> flags_out[2] == ~^acc_out);

   assert_cmp_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_op |=> $stable(acc_out));

   assert_logic_clears_cy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      logic_op |=> flags_out[0] == 1'b0);

   assert_incdec_keeps_cy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      incdec_op |=> $stable(flags_out[0]));

   assert_quiet_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
      quiet_op |=> $stable(flags_out));

   assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> ($stable(acc_out) && $stable(flags_out)));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_code(op_code),
   .acc_out(acc_out), .flags_out(flags_out)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_en = 1'b0, exec_en = 1'b0;
   logic [3:0] op_code = 4'h0;
   logic [7:0] operand = 8'h00;
   logic [7:0] acc_out, flags_out;

   int total = 0, bad = 0;
   bit done = 1'b0;

   int m_acc, m_tmp, m_s, m_z, m_ac, m_p, m_cy;
   int unsigned lfsr = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_alu u_dut (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .exec_en(exec_en),
      .op_code(op_code), .operand(operand), .acc_out(acc_out), .flags_out(flags_out)
   );

   function automatic string op_tag(bit ex, int op);
      if (!ex) return "R13";
      if (op <= 1) return "R3";
      if (op == 2 || op == 3 || op == 7) return "R4";
      if (op >= 4 && op <= 6) return "R5";
      if (op >= 8 && op <= 11) return "R6";
      return "R12";
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(string tag);
      check(tag, "acc", acc_out, m_acc);
      check("R7", "sign", flags_out[7], m_s);
      check("R8", "zero", flags_out[6], m_z);
      check("R9", "aux carry", flags_out[4], m_ac);
      check("R10", "parity", flags_out[2], m_p);
      check(tag, "carry", flags_out[0], m_cy);
      check("R11", "flag byte",
            flags_out, (m_s<<7)|(m_z<<6)|(m_ac<<4)|(m_p<<2)|2|m_cy);
   endtask

   task automatic set_flags(int r, int ac);
      m_s  = (r >> 7) & 1;
      m_z  = (r == 0);
      m_p  = ($countones(r[7:0]) % 2 == 0);
      m_ac = ac;
   endtask

   task automatic step(bit ex, bit ld, int op, int val);
      int x, y, cin, sum, r, ac, co;
      bit arith;
      load_en = ld; exec_en = ex; op_code = op[3:0]; operand = val[7:0];
      if (ex) begin
         arith = 1'b1; x = m_acc; y = m_tmp; cin = 0;
         case (op)
            0: ;
            1: cin = m_cy;
            2, 7: begin y = (~m_tmp) & 255; cin = 1; end
            3: begin y = (~m_tmp) & 255; cin = (m_cy == 0); end
            8: begin y = 0; cin = 1; end
            9: y = 255;
            10: begin x = m_tmp; y = 0; cin = 1; end
            11: begin x = m_tmp; y = 255; end
            default: arith = 1'b0;
         endcase
         sum = x + y + cin;
         r   = sum & 255;
         co  = sum >> 8;
         ac  = ((x & 15) + (y & 15) + cin) >> 4;
         case (op)
            0, 1: begin m_acc = r; set_flags(r, ac); m_cy = co; end
            2, 3: begin m_acc = r; set_flags(r, ac); m_cy = (co == 0); end
            7: begin set_flags(r, ac); m_cy = (co == 0); end
            4: begin m_acc = m_acc & m_tmp; set_flags(m_acc, 1); m_cy = 0; end
            5: begin m_acc = m_acc | m_tmp; set_flags(m_acc, 0); m_cy = 0; end
            6: begin m_acc = m_acc ^ m_tmp; set_flags(m_acc, 0); m_cy = 0; end
            8, 9: begin m_acc = r; set_flags(r, ac); end
            10, 11: begin m_tmp = r; set_flags(r, ac); end
            12: m_acc = m_tmp;
            default: ;
         endcase
         if (!arith) sum = 0;
      end
      if (ld) m_tmp = val & 255;
      @(posedge clk);
      @(negedge clk);
      compare_all(ld && ex ? "R2" : (ld && !ex ? "R2" : op_tag(ex, op)));
   endtask

   function automatic int unsigned next_rand();
      lfsr ^= lfsr << 13;
      lfsr ^= lfsr >> 17;
      lfsr ^= lfsr << 5;
      return lfsr;
   endfunction

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL R13 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      m_acc = 0; m_tmp = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare_all("R1");                // reset state during reset
      rst_n = 1'b1;
      step(1, 0, 12, 0);                // R1: operand register starts at 0
      // R3: FF + 01 wraps to 0 with carry and nibble carry
      step(0, 1, 0, 8'h01);
      step(1, 1, 12, 8'hFF);            // R2: uses old operand (01), then loads FF
      step(1, 0, 0, 0);                 // acc 01 + FF
      step(1, 0, 1, 0);                 // add with carry
      step(0, 1, 0, 8'h0F);
      step(1, 0, 0, 0);                 // nibble carry case
      // R4: subtract/borrow/compare
      step(1, 1, 2, 8'h20);
      step(1, 0, 2, 0);
      step(1, 0, 3, 0);
      step(1, 0, 7, 0);
      step(1, 1, 7, 8'h00);             // compare equal to operand? uses old
      step(1, 0, 7, 0);
      // R5: logic ops
      step(1, 1, 4, 8'hA5);
      step(1, 0, 4, 0);
      step(1, 0, 5, 0);
      step(1, 0, 6, 0);
      step(1, 0, 6, 0);
      // R6: inc/dec on both registers, carry preserved
      step(0, 1, 0, 8'h01);
      step(1, 0, 11, 0);                // operand becomes 0, Z set
      step(1, 0, 11, 0);                // wraps to FF
      step(1, 0, 10, 0);
      step(1, 0, 12, 0);
      step(1, 0, 8, 0);
      step(1, 0, 9, 0);
      step(1, 0, 9, 0);
      step(1, 1, 10, 8'h7E);            // R2: load wins over increment
      step(1, 0, 12, 0);
      // R12 / R13: unused codes and idle
      step(1, 0, 13, 0);
      step(1, 0, 14, 0);
      step(1, 0, 15, 0);
      step(0, 0, 0, 0);
      step(0, 0, 7, 0);
      for (int i = 0; i < 1500; i++) begin
         int unsigned rv;
         rv = next_rand();
         step(rv[0] | rv[1], rv[2] & rv[3], int'(rv[11:8]), int'(rv[23:16]));
      end
      done = 1'b1;
      summary();
      $finish;
   end
endmodule